// File: doc/BRIEF.md
# Split-Read Maskable Interrupt Latch

This block holds a 32-bit register of sticky event flags and a 32-bit enable mask. It drives one active-low attention line to a host. An event pulse sets its flag bit. The bit stays set until the host reads the 16-bit half that contains it. The host sees the register as two 16-bit read values, a lower half and an upper half. A read strobe for a half marks the cycle in which the host takes that half's value.

The attention line goes low when a flag with its mask bit at 1 is set. It goes high again as soon as the host reads either half. Once it has fired, it cannot fire again until the host has read both halves. A host that reads only one half gets no more interrupts, so a service routine always sees the whole register before it is interrupted again.

Top module: `split_irq_latch`

## Requirements
- R1: After reset all flags read as 0, the mask is all zeros, `irq_n` is 1, and the re-arm state counts both halves as already read.
- R2: An event pulse on `evt_set[k]` makes flag k read as 1 from the next cycle on. Flags 15..0 appear on `lo_data[15:0]` and flags 31..16 on `hi_data[15:0]`. A set flag stays set with no further pulse.
- R3: A cycle with `rd_lo` high clears flags 15..0 from the next cycle on, and a cycle with `rd_hi` high clears flags 31..16. The half that is not read is unchanged.
- R4: An event pulse in the same cycle as the read strobe of its own half leaves that flag set after the read.
- R5: A mask write (`mask_we` high) loads `mask_wdata` and takes effect from the next cycle. Mask bit k at 1 enables flag k. A flag whose mask bit is 0 never causes `irq_n` to go low.
- R6: `irq_n` goes low in the cycle after a cycle that meets all four conditions: `irq_n` is high, both halves have been read since the last assertion (or since reset), at least one flag with its mask bit at 1 is set, and neither read strobe is high.
- R7: While `irq_n` is low, a cycle with `rd_lo` or `rd_hi` high makes `irq_n` high in the next cycle.
- R8: After an assertion, `irq_n` stays high until both halves have been read at least once each. Reading the same half several times is not enough.
- R9: While `irq_n` is low and no read strobe is high, `irq_n` stays low, whatever happens to the flags, events or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_set | input | 32 | Event set pulses, one per flag |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 32 | New mask value |
| rd_lo | input | 1 | Host reads the lower half this cycle |
| rd_hi | input | 1 | Host reads the upper half this cycle |
| lo_data | output | 16 | Current flags 15..0 |
| hi_data | output | 16 | Current flags 31..16 |
| irq_n | output | 1 | Attention line, active low |

## Verification
The bench reads only one half, twice, while a flag in the other half is still pending. A design that re-arms on any read would assert the line again at that point. It drives an event into the same cycle as the read of its half, where a design that gives the clear priority would lose the flag. It also clears the mask while the line is low, reads in the same cycle that the re-arm conditions are met, and finishes with a long random run. A design that lets the line follow the pending condition would drop it early there, or fire it while a read is in progress.

// File: rtl/split_irq_latch_pkg.sv
package split_irq_latch_pkg;

    localparam int HALF_W_DEF = 16;
    localparam int N_HALVES   = 2;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;

    // Re-arm record: one bit per half, set once that half is read.
    typedef struct packed {
        logic hi;
        logic lo;
    } arm_t;

    localparam arm_t ARM_RESET = '{hi: 1'b1, lo: 1'b1};
    localparam arm_t ARM_NONE  = '{hi: 1'b0, lo: 1'b0};

    function automatic logic both_seen(input arm_t a);
        return a.lo & a.hi;
    endfunction

    function automatic arm_t mark_reads(input arm_t a, input logic [N_HALVES-1:0] rd);
        arm_t r;
        r.lo = a.lo | rd[HALF_LO];
        r.hi = a.hi | rd[HALF_HI];
        return r;
    endfunction

endpackage

// File: rtl/slrl_flag_bank.sv
module slrl_flag_bank #(
    parameter int HALF_W = 16,
    parameter int N_HALF = 2,
    localparam int FLAG_W = HALF_W * N_HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] evt,
    input  logic [N_HALF-1:0] rd,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] flags_q;

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        // A read clears the half, but an event in that cycle wins.
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[h*HALF_W +: HALF_W] <= '0;
            end else begin
                flags_q[h*HALF_W +: HALF_W] <=
                    (rd[h] ? {HALF_W{1'b0}} : flags_q[h*HALF_W +: HALF_W])
                    | evt[h*HALF_W +: HALF_W];
            end
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/slrl_arm_ctrl.sv
module slrl_arm_ctrl
    import split_irq_latch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pending,
    input  logic [N_HALVES-1:0] rd,
    output logic                active,
    output arm_t                arm
);

    logic active_q;
    arm_t arm_q;
    logic rd_any;
    logic fire;

    assign rd_any = |rd;
    assign fire   = !active_q && both_seen(arm_q) && pending && !rd_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            arm_q    <= ARM_RESET;
        end else begin
            if (fire) begin
                active_q <= 1'b1;
                arm_q    <= ARM_NONE;
            end else begin
                if (active_q && rd_any) begin
                    active_q <= 1'b0;
                end
                arm_q <= mark_reads(arm_q, rd);
            end
        end
    end

    assign active = active_q;
    assign arm    = arm_q;

endmodule

// File: rtl/split_irq_latch.sv
module split_irq_latch
    import split_irq_latch_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF,
    localparam int FLAG_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] evt_set,
    input  logic              mask_we,
    input  logic [FLAG_W-1:0] mask_wdata,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [HALF_W-1:0] lo_data,
    output logic [HALF_W-1:0] hi_data,
    output logic              irq_n
);

    logic [FLAG_W-1:0]   mask_q;
    logic [FLAG_W-1:0]   flags;
    logic [N_HALVES-1:0] rd_vec;
    logic                pending;
    logic                active;
    arm_t                arm_q;

    assign rd_vec[HALF_LO] = rd_lo;
    assign rd_vec[HALF_HI] = rd_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    slrl_flag_bank #(
        .HALF_W (HALF_W),
        .N_HALF (N_HALVES)
    ) u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_set),
        .rd    (rd_vec),
        .flags (flags)
    );

    assign pending = |(flags & mask_q);

    slrl_arm_ctrl u_arm (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .rd      (rd_vec),
        .active  (active),
        .arm     (arm_q)
    );

    assign lo_data = flags[HALF_W-1:0];
    assign hi_data = flags[FLAG_W-1:HALF_W];
    assign irq_n   = ~active;

endmodule

// File: rtl/split_irq_latch_chk.sv
module split_irq_latch_chk #(
    parameter int HALF_W = 16,
    localparam int FLAG_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic [FLAG_W-1:0] evt_set,
    input logic              rd_lo,
    input logic              rd_hi,
    input logic [HALF_W-1:0] lo_data,
    input logic [HALF_W-1:0] hi_data,
    input logic              irq_n,
    input logic [FLAG_W-1:0] mask_q,
    input logic [1:0]        arm
);

    logic [FLAG_W-1:0] seen;
    assign seen = {hi_data, lo_data};

    // R2: a pulsed flag is visible the next cycle
    a_r2_event_sticks: assert property (@(posedge clk) disable iff (rst)
        (evt_set != '0) |=> ((seen & $past(evt_set)) == $past(evt_set)));

    // R3: a read with no coinciding event leaves the half empty
    a_r3_lo_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && evt_set[HALF_W-1:0] == '0) |=> (lo_data == '0));

    // R4: an event in the read cycle survives the read
    a_r4_event_beats_read: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> ((hi_data & $past(evt_set[FLAG_W-1:HALF_W])) == $past(evt_set[FLAG_W-1:HALF_W])));

    // R5: nothing unmasked pending keeps the line high
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_n && (seen & mask_q) == '0) |=> irq_n);

    // R6: an assertion needs both halves read and no read in progress
    a_r6_fire_cond: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(arm == 2'b11 && !rd_lo && !rd_hi));

    // R7: any read drops the line
    a_r7_read_drops: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && (rd_lo || rd_hi)) |=> irq_n);

    // R8: not re-armed means no assertion
    a_r8_no_rearm: assert property (@(posedge clk) disable iff (rst)
        (irq_n && arm != 2'b11) |=> irq_n);

    // R9: the line holds while no read occurs
    a_r9_holds: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !rd_lo && !rd_hi) |=> !irq_n);

endmodule

bind split_irq_latch split_irq_latch_chk #(.HALF_W(HALF_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_set (evt_set),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi),
    .lo_data (lo_data),
    .hi_data (hi_data),
    .irq_n   (irq_n),
    .mask_q  (mask_q),
    .arm     (arm_q)
);

// File: tb/split_irq_latch_tb.sv
module split_irq_latch_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] evt_set;
    logic        mask_we;
    logic [31:0] mask_wdata;
    logic        rd_lo;
    logic        rd_hi;
    logic [15:0] lo_data;
    logic [15:0] hi_data;
    logic        irq_n;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    string req   = "R1";

    // behavioural reference state
    bit [31:0] m_flags;
    bit [31:0] m_mask;
    bit        m_irq;
    bit        m_lo_read;
    bit        m_hi_read;

    always #10 clk = ~clk;

    split_irq_latch u_dut (
        .clk        (clk),
        .rst        (rst),
        .evt_set    (evt_set),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .lo_data    (lo_data),
        .hi_data    (hi_data),
        .irq_n      (irq_n)
    );

    task automatic check_outputs();
        checks++;
        if (lo_data !== m_flags[15:0] || hi_data !== m_flags[31:16] || irq_n !== !m_irq) begin
            failures++;
            $display("FAIL %s: lo=%h hi=%h irq_n=%b expected lo=%h hi=%h irq_n=%b",
                     req, lo_data, hi_data, irq_n, m_flags[15:0], m_flags[31:16], !m_irq);
        end
    endtask

    task automatic model_step(input bit [31:0] e, input bit we, input bit [31:0] wd,
                              input bit rl, input bit rh);
        bit any_pending;
        any_pending = (m_flags & m_mask) != 0;
        if (!m_irq && m_lo_read && m_hi_read && any_pending && !rl && !rh) begin
            m_irq = 1;
            m_lo_read = 0;
            m_hi_read = 0;
        end else begin
            if (rl || rh) m_irq = 0;
            if (rl) m_lo_read = 1;
            if (rh) m_hi_read = 1;
        end
        if (rl) m_flags[15:0] = 16'h0;
        if (rh) m_flags[31:16] = 16'h0;
        m_flags = m_flags | e;
        if (we) m_mask = wd;
    endtask

    // Drive at negedge, clock, then compare at the following negedge.
    task automatic cyc(input bit [31:0] e, input bit we, input bit [31:0] wd,
                       input bit rl, input bit rh);
        evt_set = e; mask_we = we; mask_wdata = wd; rd_lo = rl; rd_hi = rh;
        @(posedge clk);
        model_step(e, we, wd, rl, rh);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(32'h0, 0, 32'h0, 0, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; evt_set = 0; mask_we = 0; mask_wdata = 0; rd_lo = 0; rd_hi = 0;
        m_flags = 0; m_mask = 0; m_irq = 0; m_lo_read = 1; m_hi_read = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        req = "R1"; check_outputs();
        idle(2);

        // R2 and R5: flags set with mask zero, no interrupt
        req = "R5"; cyc(32'h0001_0004, 0, 0, 0, 0);
        idle(3);
        req = "R2"; cyc(32'h8000_0000, 0, 0, 0, 0);
        idle(2);

        // R6: enable one upper flag, line falls
        req = "R6"; cyc(0, 1, 32'h0001_0000, 0, 0);
        idle(3);

        // R9: mask cleared and new events while low, line holds
        req = "R9"; cyc(32'h0000_0100, 1, 32'h0, 0, 0);
        idle(2);
        cyc(0, 1, 32'hFFFF_FFFF, 0, 0);

        // R7 and R3: lower read drops the line and clears only the lower half
        req = "R7"; cyc(0, 0, 0, 1, 0);
        req = "R3"; idle(2);

        // R8: reading the lower half again does not re-arm
        req = "R8"; cyc(0, 0, 0, 1, 0);
        idle(4);
        cyc(32'h0000_0002, 0, 0, 1, 0);
        idle(3);

        // R4: event in the upper read cycle survives; both read, so re-fire
        req = "R4"; cyc(32'h0002_0000, 0, 0, 0, 1);
        req = "R6"; idle(3);

        // R8: upper-only reads after the next drop
        req = "R8"; cyc(0, 0, 0, 0, 1);
        cyc(32'h0004_0000, 0, 0, 0, 1);
        idle(3);
        // R6: read in the cycle the conditions meet, no fire that cycle
        req = "R6"; cyc(32'h0000_0001, 0, 0, 1, 0);
        idle(2);
        // R7: both halves read together
        req = "R7"; cyc(0, 0, 0, 1, 1);
        idle(3);

        // R5: mask off everything, clear flags, then set masked events
        req = "R5"; cyc(0, 1, 32'h0, 1, 1);
        cyc(32'hF0F0_0F0F, 0, 0, 0, 0);
        idle(3);
        cyc(0, 1, 32'h0000_0F00, 0, 0);
        idle(2);

        // Random mixture of all inputs
        req = "R2";
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] e;
            bit rl, rh, we;
            e  = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            rl = ($urandom % 7) == 0;
            rh = ($urandom % 7) == 0;
            we = ($urandom % 40) == 0;
            req = (i % 2 == 0) ? "R3" : "R8";
            cyc(e, we, $urandom, rl, rh);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule